// File: doc/BRIEF.md
# Phase-Frequency Detector with Override Modes

This block takes two pulse streams, a reference pulse and the divided-oscillator pulse, samples both on the system clock, and turns their rising edges into pump-up and pump-down requests for a downstream charge pump. A rising reference edge raises the pump-up request and a rising divider edge raises the pump-down request. When both requests are up, they are cleared together on the next clock. A request therefore lasts as long as one stream leads the other. The detector responds to frequency error as well as phase error: extra edges on the leading stream keep its request high until the lagging stream catches up.

A three-bit control word picks one of four output modes. Several codes share the same mode. The modes are normal detection, off (output not driven), forced pump-up and forced pump-down. An output-enable signal stands in for the tri-state driver of the analog pump. The mode is held in a registered state machine with the states OFF, NORMAL, HIGH and LOW. Any state can move to any other, one clock after the control word changes. Reset puts it in OFF.

The pump pairing is a second state machine with four states. IDLE moves to UP on a reference edge, to DN on a divider edge, and to BOTH when both edges arrive together. UP moves to BOTH on a divider edge. DN moves to BOTH on a reference edge. BOTH always leaves after one cycle, to IDLE, or to UP, DN or BOTH if new edges arrive in that same cycle. When the next mode is not NORMAL, every state returns to IDLE.

Top module: `pfd_override`

## Requirements
- R1: Control codes 000, 100 and 110 (bit order ctrl[2], ctrl[1], ctrl[0]) select normal mode: drive_en is 1 and pump_up/pump_dn follow the detector.
- R2: Control codes 001, 101 and 111 select off mode: drive_en, pump_up and pump_dn are all 0.
- R3: Control code 010 forces pump_up=1, pump_dn=0, drive_en=1.
- R4: Control code 011 forces pump_up=0, pump_dn=1, drive_en=1.
- R5: A change of the control word shows at the outputs after the next rising clock edge, not before.
- R6: In normal mode, a rising reference edge raises pump_up after the clock edge that samples it. A reference level that stays high does not count as another edge.
- R7: In normal mode, a rising divider edge raises pump_dn after the clock edge that samples it.
- R8: When both requests are high, both are cleared on the next clock, unless a new edge arrives in that cycle. pump_up and pump_dn are never both 1 for two cycles in a row.
- R9: Frequency sensitivity: further reference edges while pump_up is already high and pump_dn low leave pump_up high and pump_dn low. The same holds with the two streams swapped.
- R10: Leaving normal mode clears both requests. On return to normal, both start at 0, and input levels that are already high do not count as edges.
- R11: Synchronous active-high reset selects off mode and clears both requests and the edge history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_pulse | input | 1 | Reference pulse stream |
| div_pulse | input | 1 | Divided-oscillator pulse stream |
| ctrl | input | 3 | Mode control word |
| pump_up | output | 1 | Pump-up request |
| pump_dn | output | 1 | Pump-down request |
| drive_en | output | 1 | Output enable; 0 means the pump is not driven |

## Verification
The bench checks that all eight control codes reach the right mode. A decoder that merged the wrong codes would drive the pump when it should be off, or force the wrong direction. It sends simultaneous edges and edges that arrive in the clearing cycle. A detector with a broken reset path would hold both requests high together, and one that dropped edges in that cycle would lose phase information. It repeats edges on one stream to check frequency sensitivity: a phase-only detector would let the request fall. It leaves normal mode in the middle of a request, with the inputs held high, and then returns. Stale requests or false edges would then show up as a pump pulse right after the return to normal mode.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
    localparam int CTRL_W = 3;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'd0,
        MODE_NORMAL = 2'd1,
        MODE_HIGH   = 2'd2,
        MODE_LOW    = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_UP   = 2'd1,
        ST_DN   = 2'd2,
        ST_BOTH = 2'd3
    } pump_e;
endpackage

// File: rtl/pfd_mode_ctl.sv
module pfd_mode_ctl
    import pfd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CTRL_W-1:0] ctrl,
    output mode_e             mode_d,
    output mode_e             mode_q
);
    // Decode of the control word; several codes alias onto one mode.
    always_comb begin
        unique case (ctrl)
            3'b000, 3'b100, 3'b110: mode_d = MODE_NORMAL;
            3'b001, 3'b101, 3'b111: mode_d = MODE_OFF;
            3'b010:                 mode_d = MODE_HIGH;
            3'b011:                 mode_d = MODE_LOW;
            default:                mode_d = MODE_OFF;
        endcase
    end

    // Mode state register.
    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_OFF;
        else     mode_q <= mode_d;
    end

    p_mode_follows_r5: assert property (@(posedge clk) disable iff (rst)
        (ctrl == 3'b010) |=> (mode_q == MODE_HIGH));
    p_reset_off_r11: assert property (@(posedge clk)
        $past(rst) |-> (mode_q == MODE_OFF));
endmodule

// File: rtl/pfd_edge_sense.sv
module pfd_edge_sense #(
    parameter int N_IN = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_IN-1:0] level,
    output logic [N_IN-1:0] rise
);
    logic [N_IN-1:0] hist_q;

    for (genvar i = 0; i < N_IN; i++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) hist_q[i] <= 1'b0;
            else     hist_q[i] <= level[i];
        end
        assign rise[i] = level[i] & ~hist_q[i];
    end

    p_no_double_rise_r6: assert property (@(posedge clk) disable iff (rst)
        rise[0] |=> !rise[0]);
endmodule

// File: rtl/pfd_pump_fsm.sv
module pfd_pump_fsm
    import pfd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic ref_rise,
    input  logic div_rise,
    output logic up_flag,
    output logic dn_flag
);
    pump_e st_q, st_d;

    // Step out of IDLE, also used when BOTH clears.
    function automatic pump_e from_idle(logic r, logic d);
        if (r && d) return ST_BOTH;
        if (r)      return ST_UP;
        if (d)      return ST_DN;
        return ST_IDLE;
    endfunction

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: st_d = from_idle(ref_rise, div_rise);
                ST_UP:   st_d = div_rise ? ST_BOTH : ST_UP;
                ST_DN:   st_d = ref_rise ? ST_BOTH : ST_DN;
                ST_BOTH: st_d = from_idle(ref_rise, div_rise);
                default: st_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    always_comb begin
        up_flag = (st_q == ST_UP) || (st_q == ST_BOTH);
        dn_flag = (st_q == ST_DN) || (st_q == ST_BOTH);
    end

    p_leave_clears_r10: assert property (@(posedge clk) disable iff (rst)
        !run |=> (st_q == ST_IDLE));
    p_up_holds_r9: assert property (@(posedge clk) disable iff (rst)
        (run && st_q == ST_UP && !div_rise) |=> (st_q == ST_UP));
endmodule

// File: rtl/pfd_override.sv
module pfd_override
    import pfd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_pulse,
    input  logic              div_pulse,
    input  logic [CTRL_W-1:0] ctrl,
    output logic              pump_up,
    output logic              pump_dn,
    output logic              drive_en
);
    localparam int N_IN = 2;

    mode_e           mode_d, mode_q;
    logic [N_IN-1:0] rise;
    logic            up_flag, dn_flag;

    pfd_mode_ctl u_mode (
        .clk    (clk),
        .rst    (rst),
        .ctrl   (ctrl),
        .mode_d (mode_d),
        .mode_q (mode_q)
    );

    pfd_edge_sense #(.N_IN(N_IN)) u_edge (
        .clk   (clk),
        .rst   (rst),
        .level ({div_pulse, ref_pulse}),
        .rise  (rise)
    );

    pfd_pump_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .run      (mode_d == MODE_NORMAL),
        .ref_rise (rise[0]),
        .div_rise (rise[1]),
        .up_flag  (up_flag),
        .dn_flag  (dn_flag)
    );

    // Output process keyed on the mode state.
    always_comb begin
        unique case (mode_q)
            MODE_NORMAL: begin pump_up = up_flag; pump_dn = dn_flag; drive_en = 1'b1; end
            MODE_HIGH:   begin pump_up = 1'b1;    pump_dn = 1'b0;    drive_en = 1'b1; end
            MODE_LOW:    begin pump_up = 1'b0;    pump_dn = 1'b1;    drive_en = 1'b1; end
            default:     begin pump_up = 1'b0;    pump_dn = 1'b0;    drive_en = 1'b0; end
        endcase
    end

    p_off_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !drive_en |-> (!pump_up && !pump_dn));
    p_force_low_r4: assert property (@(posedge clk) disable iff (rst)
        (ctrl == 3'b011) |=> (pump_dn && !pump_up && drive_en));
    p_pair_once_r8: assert property (@(posedge clk) disable iff (rst)
        (pump_up && pump_dn) |=> !(pump_up && pump_dn));
    p_normal_en_r1: assert property (@(posedge clk) disable iff (rst)
        (ctrl == 3'b100) |=> drive_en);
endmodule

// File: tb/sim_pfd_override.sv
module sim_pfd_override;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_pulse = 1'b0;
    logic       div_pulse = 1'b0;
    logic [2:0] ctrl = 3'b001;
    logic       pump_up, pump_dn, drive_en;

    int checks = 0;
    int failures = 0;

    // Bench model state: 0 off, 1 normal, 2 high, 3 low.
    int   m_mode = 0;
    logic m_up = 0, m_dn = 0, m_rh = 0, m_dh = 0;

    always #(PERIOD/2) clk = ~clk;

    pfd_override u0 (
        .clk(clk), .rst(rst), .ref_pulse(ref_pulse), .div_pulse(div_pulse),
        .ctrl(ctrl), .pump_up(pump_up), .pump_dn(pump_dn), .drive_en(drive_en)
    );

    function automatic int dec(logic [2:0] c);
        case (c)
            3'b010:  return 2;
            3'b011:  return 3;
            3'b001, 3'b101, 3'b111: return 0;
            default: return 1;
        endcase
    endfunction

    function automatic logic [2:0] expect_out();
        case (m_mode)
            1:       return {m_up, m_dn, 1'b1};
            2:       return 3'b101;
            3:       return 3'b011;
            default: return 3'b000;
        endcase
    endfunction

    task automatic model_tick();
        logic rr, dr;
        if (rst) begin
            m_mode = 0; m_up = 0; m_dn = 0; m_rh = 0; m_dh = 0;
        end else begin
            rr = ref_pulse & ~m_rh;
            dr = div_pulse & ~m_dh;
            if (dec(ctrl) != 1) begin
                m_up = 0; m_dn = 0;
            end else if (m_up && m_dn) begin
                m_up = rr; m_dn = dr;
            end else begin
                m_up = m_up | rr; m_dn = m_dn | dr;
            end
            m_rh = ref_pulse; m_dh = div_pulse;
            m_mode = dec(ctrl);
        end
    endtask

    task automatic check(string tag);
        logic [2:0] exp, act;
        exp = expect_out();
        act = {pump_up, pump_dn, drive_en};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: {up,dn,en} actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(logic r, logic d, logic [2:0] c, string tag);
        ref_pulse = r; div_pulse = d; ctrl = c;
        @(posedge clk);
        model_tick();
        #1;
        check(tag);
    endtask

    initial begin
        #(PERIOD*200000);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int unsigned seed;
        logic [2:0] rc;
        seed = $urandom(32'd12345);
        // R11: reset state
        rst = 1;
        step(0, 0, 3'b000, "R11");
        step(0, 0, 3'b000, "R11");
        rst = 0;
        // R5: mode change lands one clock later; first sample before edge
        ctrl = 3'b010;
        #1;
        checks++;
        if (drive_en !== 1'b0) begin
            failures++;
            $display("FAIL R5: en actual=%b expected=0", drive_en);
        end
        step(0, 0, 3'b010, "R3");
        step(0, 0, 3'b011, "R4");
        step(0, 0, 3'b001, "R2");
        step(0, 0, 3'b101, "R2");
        step(0, 0, 3'b111, "R2");
        step(0, 0, 3'b000, "R1");
        step(0, 0, 3'b100, "R1");
        step(0, 0, 3'b110, "R1");
        // R6 then R9: repeated ref edges, held level
        step(1, 0, 3'b000, "R6");
        step(1, 0, 3'b000, "R6");
        step(0, 0, 3'b000, "R9");
        step(1, 0, 3'b000, "R9");
        step(0, 1, 3'b000, "R8");
        step(0, 1, 3'b000, "R8");
        // R7 then R9 mirrored
        step(0, 0, 3'b000, "R7");
        step(0, 1, 3'b000, "R7");
        step(0, 0, 3'b000, "R9");
        step(0, 1, 3'b000, "R9");
        step(1, 0, 3'b000, "R8");
        step(0, 0, 3'b000, "R8");
        // R8: simultaneous edges, then a new edge during the clearing cycle
        step(1, 1, 3'b000, "R8");
        step(0, 0, 3'b000, "R8");
        step(1, 1, 3'b000, "R8");
        step(1, 1, 3'b000, "R8");
        step(0, 0, 3'b000, "R8");
        step(1, 0, 3'b000, "R8");
        step(0, 1, 3'b000, "R8");
        // R10: leave normal mid-request with inputs high, then return
        step(1, 0, 3'b000, "R10");
        step(1, 0, 3'b011, "R10");
        step(1, 1, 3'b001, "R10");
        step(1, 1, 3'b100, "R10");
        step(1, 1, 3'b100, "R10");
        step(0, 0, 3'b100, "R10");
        // Random mix
        for (int i = 0; i < 4000; i++) begin
            rc = ($urandom % 4 != 0) ? 3'b000 : 3'($urandom);
            if (rc == 3'b000) rc = ($urandom % 2) ? 3'b110 : rc;
            step(1'($urandom % 3 == 0), 1'($urandom % 3 == 0), rc,
                 (dec(rc) == 1) ? "R1" : "R5");
            if (pump_up && pump_dn && m_up && m_dn) begin
                step(0, 0, rc, "R8");
            end
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule